// File: doc/BRIEF.md
# Receive FIFO with Per-Character Status

This block is the receive half of a serial port controller. A deserializer outside the block hands it one character at a time, together with three error flags for that character: a break was seen, the stop bit was wrong, or parity failed. The block keeps a 16-deep queue. Each slot holds the byte and its flags, and a fourth flag that marks an overrun. A register-style read port shows the character at the head of the queue, and a pop strobe removes it.

A 16-bit status word describes the head character and the queue. It gives the head's error flags, an empty indication that reads 1 when nothing is waiting, the fill count, and two sticky interrupt causes. The first cause is a fill-level trigger with four selectable thresholds. The second is an idle timeout, raised when characters sit below the threshold and no new ones arrive. Software clears either cause by writing 0 to its bit.

A receive-queue reset takes effect only when an enable line is held with it. A software reset clears everything, and its busy flag stays 1 until the clearing sequence has run.

Top module: `rxfifo_status`

## Requirements
- R1: Accepted characters leave in arrival order. `rd_data` shows the head byte, and `rd_pop` removes it. A pop when the queue is empty has no effect.
- R2: Status bits 4:0 give the number of stored characters, from 0 to DEPTH (16).
- R3: Status bit 14 is 1 when the queue is empty and 0 when a character can be read.
- R4: For the head character, status bit 15 gives break, bit 13 framing error, bit 12 parity error and bit 11 overrun. All four read 0 when the queue is empty.
- R5: `cfg_trig` values 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 12 characters. Status bit 7 becomes 1 in the cycle after an accepted character brings the count to or above the threshold.
- R6: A status write with bit 7 or bit 9 at 0 clears that bit. A 1 in that position leaves the bit unchanged. A setting event in the same cycle wins over the clear.
- R7: A character that arrives while the queue is full, with no pop in the same cycle, is dropped. The count stays at DEPTH, and the newest stored entry gets its overrun flag set.
- R8: Status bit 9 is set when the queue is non-empty and below the threshold and TOUT_CHARS (4) `char_tick` pulses occur with no new arrival. Each arrival restarts the count.
- R9: `fifo_rst_rx` empties the queue only while `fifo_rst_en` is also 1. On its own it has no effect.
- R10: A `sw_rst` pulse sets `rst_busy` for RST_CYCLES (4) cycles. After the pulse the queue is empty and status bits 7 and 9 are 0. Arrivals are ignored while `rst_busy` is 1.
- R11: With `cfg_seven` at 1, bit 7 of every stored byte is forced to 0.
- R12: `irq` is 1 exactly when status bit 7 or status bit 9 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Deserializer delivers a character this cycle |
| rx_data | input | 8 | Received byte |
| rx_brk | input | 1 | Break seen for this character |
| rx_fer | input | 1 | Framing error for this character |
| rx_per | input | 1 | Parity error for this character |
| char_tick | input | 1 | One pulse per character time |
| cfg_trig | input | 2 | Fill-trigger select |
| cfg_seven | input | 1 | 7-bit character mode |
| rd_pop | input | 1 | Read of the data port; pops the head entry |
| rd_data | output | 8 | Head byte, 0 when empty |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Status write value; only bits 7 and 9 are used |
| stat | output | 16 | Status word |
| fifo_rst_en | input | 1 | Enable for the queue reset |
| fifo_rst_rx | input | 1 | Receive queue reset |
| sw_rst | input | 1 | Software reset request |
| rst_busy | output | 1 | Software reset in progress |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: DEPTH 16, TOUT_CHARS 4 and RST_CYCLES 4. At this size every trigger setting can be swept from empty to full and past full in a few dozen cycles, so each threshold crossing, the drop at a full queue and the overrun mark on the sixteenth entry are all reached. The short timeout and reset windows let the bench count the ticks and cycles exactly, one below and one at the limit.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              fer;
    logic              per;
    logic              ovr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  // Fill threshold chosen by the two-bit trigger select.
  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 12;
    endcase
  endfunction

  // Clears the top data bit when 7-bit mode is selected.
  function automatic logic [DATA_W-1:0] fit_width(input logic [DATA_W-1:0] d,
                                                  input logic seven);
    logic [DATA_W-1:0] m;
    m = {DATA_W{1'b1}};
    if (seven) m[DATA_W-1] = 1'b0;
    return d & m;
  endfunction

  // Builds the status word. The head flags read 0 when the queue is empty.
  function automatic logic [15:0] pack_status(input rx_entry_t head, input logic empty,
                                               input logic tout, input logic rdis,
                                               input logic [4:0] cnt);
    logic [15:0] s;
    s        = '0;
    s[15]    = head.brk & ~empty;
    s[14]    = empty;
    s[13]    = head.fer & ~empty;
    s[12]    = head.per & ~empty;
    s[11]    = head.ovr & ~empty;
    s[9]     = tout;
    s[7]     = rdis;
    s[4:0]   = cnt;
    return s;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic               pop,
  input  rxf_pkg::rx_entry_t wr_entry,
  output rxf_pkg::rx_entry_t head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH+1)-1:0] count_nxt,
  output logic               empty,
  output logic               full,
  output logic               push_ok,
  output logic               pop_ok,
  output logic               drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  rxf_pkg::rx_entry_t mem [DEPTH];
  logic [AW-1:0] wptr, rptr, last_ptr;

  always_comb begin
    empty    = (count == '0);
    full     = (count == CW'(DEPTH));
    pop_ok   = pop && !empty;
    push_ok  = push && (!full || pop_ok);
    drop     = push && !push_ok;
    last_ptr = wptr - AW'(1);
    case ({push_ok, pop_ok})
      2'b10:   count_nxt = count + CW'(1);
      2'b01:   count_nxt = count - CW'(1);
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
      count <= count_nxt;
    end
  end

  // A dropped arrival marks the newest stored entry with the overrun flag.
  always_ff @(posedge clk) begin
    if (!clr) begin
      if (push_ok)   mem[wptr]         <= wr_entry;
      else if (drop) mem[last_ptr].ovr <= 1'b1;
    end
  end

  assign head = mem[rptr];
endmodule

// File: rtl/rxf_tout.sv
module rxf_tout #(
  parameter int TOUT_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic arm,
  input  logic restart,
  output logic fire
);
  localparam int TW = $clog2(TOUT_CHARS+1);
  logic [TW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         idle_cnt <= '0;
    else if (clr || restart || !arm)    idle_cnt <= '0;
    else if (tick && idle_cnt < TW'(TOUT_CHARS)) idle_cnt <= idle_cnt + TW'(1);
  end

  assign fire = arm && !restart && !clr && tick && (idle_cnt == TW'(TOUT_CHARS-1));
endmodule

// File: rtl/rxf_rstseq.sv
module rxf_rstseq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy
);
  localparam int RW = $clog2(RST_CYCLES+1);
  logic [RW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= '0;
    else if (req)        left <= RW'(RST_CYCLES);
    else if (left != '0) left <= left - RW'(1);
  end

  assign busy = (left != '0);
endmodule

// File: rtl/rxfifo_status.sv
module rxfifo_status #(
  parameter int DEPTH      = 16,
  parameter int TOUT_CHARS = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic [rxf_pkg::DATA_W-1:0] rx_data,
  input  logic                       rx_brk,
  input  logic                       rx_fer,
  input  logic                       rx_per,
  input  logic                       char_tick,
  input  logic [1:0]                 cfg_trig,
  input  logic                       cfg_seven,
  input  logic                       rd_pop,
  output logic [rxf_pkg::DATA_W-1:0] rd_data,
  input  logic                       stat_wr,
  input  logic [15:0]                stat_wdata,
  output logic [15:0]                stat,
  input  logic                       fifo_rst_en,
  input  logic                       fifo_rst_rx,
  input  logic                       sw_rst,
  output logic                       rst_busy,
  output logic                       irq
);
  import rxf_pkg::*;
  localparam int CW = $clog2(DEPTH+1);

  rx_entry_t     wr_entry, head;
  logic [CW-1:0] count, count_nxt;
  logic          empty, full, push_ok, pop_ok, drop_evt;
  logic          clr_all, store_clr, rdis_evt, tout_evt, arm;
  logic          rdis_q, tout_q;
  logic [CW-1:0] thr;
  logic          unused_wd;

  assign unused_wd = ^{stat_wdata[15:10], stat_wdata[8], stat_wdata[6:0]};

  assign clr_all   = sw_rst | rst_busy;
  assign store_clr = clr_all | (fifo_rst_en & fifo_rst_rx);
  assign thr       = CW'(trig_level(cfg_trig));

  always_comb begin
    wr_entry.data = fit_width(rx_data, cfg_seven);
    wr_entry.brk  = rx_brk;
    wr_entry.fer  = rx_fer;
    wr_entry.per  = rx_per;
    wr_entry.ovr  = 1'b0;
  end

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(store_clr),
    .push(rx_valid & ~clr_all), .pop(rd_pop),
    .wr_entry(wr_entry), .head(head),
    .count(count), .count_nxt(count_nxt),
    .empty(empty), .full(full),
    .push_ok(push_ok), .pop_ok(pop_ok), .drop(drop_evt)
  );

  assign arm = !empty && (count < thr);

  rxf_tout #(.TOUT_CHARS(TOUT_CHARS)) u_tout (
    .clk(clk), .rst_n(rst_n), .clr(store_clr), .tick(char_tick),
    .arm(arm), .restart(push_ok), .fire(tout_evt)
  );

  rxf_rstseq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .req(sw_rst), .busy(rst_busy)
  );

  assign rdis_evt = push_ok && (count_nxt >= thr);

  // A 0 written into a sticky bit clears it; a setting event in the same cycle wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdis_q <= 1'b0;
      tout_q <= 1'b0;
    end else if (clr_all) begin
      rdis_q <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      rdis_q <= rdis_evt | (rdis_q & ~(stat_wr & ~stat_wdata[7]));
      tout_q <= tout_evt | (tout_q & ~(stat_wr & ~stat_wdata[9]));
    end
  end

  assign stat    = pack_status(head, empty, tout_q, rdis_q, 5'(count));
  assign rd_data = empty ? '0 : head.data;
  assign irq     = rdis_q | tout_q;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       full,
  input logic                       push_ok,
  input logic                       pop_ok,
  input logic                       rx_valid,
  input logic                       rd_pop,
  input logic                       store_clr,
  input logic                       empty,
  input logic                       st_empty,
  input logic                       st_rdis,
  input logic                       st_tout,
  input logic                       stat_wr,
  input logic                       wd_rdis,
  input logic                       clr_all,
  input logic                       rst_busy
);
  // R2
  count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH));

  // R3
  empty_after_last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 1 && pop_ok && !push_ok) |=> st_empty);

  // R1
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok && !store_clr) |=> (count == $past(count) - 1'b1));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_valid && !rd_pop && !store_clr) |=> (count == ($clog2(DEPTH+1))'(DEPTH)));

  // R6
  rdis_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rdis && stat_wr && wd_rdis && !clr_all) |=> st_rdis);

  // R10
  busy_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |=> (count == 0 && !st_rdis && !st_tout));

  // R8
  tout_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_tout) |-> $past(!empty));
endmodule

bind rxfifo_status rxf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .full(full),
  .push_ok(push_ok), .pop_ok(pop_ok), .rx_valid(rx_valid), .rd_pop(rd_pop),
  .store_clr(store_clr), .empty(empty), .st_empty(stat[14]),
  .st_rdis(stat[7]), .st_tout(stat[9]), .stat_wr(stat_wr),
  .wd_rdis(stat_wdata[7]), .clr_all(clr_all), .rst_busy(rst_busy)
);

// File: tb/rxfifo_status_test.sv
module rxfifo_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_brk = 1'b0, rx_fer = 1'b0, rx_per = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        char_tick = 1'b0;
  logic [1:0]  cfg_trig = '0;
  logic        cfg_seven = 1'b0;
  logic        rd_pop = 1'b0;
  logic [7:0]  rd_data;
  logic        stat_wr = 1'b0;
  logic [15:0] stat_wdata = '0;
  logic [15:0] stat;
  logic        fifo_rst_en = 1'b0, fifo_rst_rx = 1'b0, sw_rst = 1'b0;
  logic        rst_busy, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rxfifo_status uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_brk(rx_brk), .rx_fer(rx_fer), .rx_per(rx_per), .char_tick(char_tick),
    .cfg_trig(cfg_trig), .cfg_seven(cfg_seven), .rd_pop(rd_pop), .rd_data(rd_data),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat(stat),
    .fifo_rst_en(fifo_rst_en), .fifo_rst_rx(fifo_rst_rx), .sw_rst(sw_rst),
    .rst_busy(rst_busy), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] d, input logic b, input logic f, input logic p);
    rx_valid = 1'b1; rx_data = d; rx_brk = b; rx_fer = f; rx_per = p;
    tick();
    rx_valid = 1'b0; rx_brk = 1'b0; rx_fer = 1'b0; rx_per = 1'b0;
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    tick();
    rd_pop = 1'b0;
  endtask

  task automatic wstat(input logic [15:0] v);
    stat_wr = 1'b1; stat_wdata = v;
    tick();
    stat_wr = 1'b0;
  endtask

  task automatic qreset();
    fifo_rst_en = 1'b1; fifo_rst_rx = 1'b1;
    tick();
    fifo_rst_en = 1'b0; fifo_rst_rx = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1'b1;
      tick();
      char_tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] pat(input int t, input int k);
    return 8'((t * 37 + k * 11 + 5) % 256);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R3 reset status", int'(stat), 16'h4000);
    check("R12 reset irq", int'(irq), 0);
    check("R10 reset busy", int'(rst_busy), 0);
    pop();
    check("R1 pop on empty", int'(stat[4:0]), 0);

    // Sweep every trigger level from empty through full and one past it.
    for (int t = 0; t < 4; t++) begin
      int thr;
      thr = (t == 0) ? 1 : 4 * t;
      cfg_trig = 2'(t);
      qreset();
      wstat(16'h0000);
      for (int k = 1; k <= 16; k++) begin
        push(pat(t, k), (k % 5) == 0, (k % 3) == 0, (k % 4) == 1);
        check("R2 count", int'(stat[4:0]), k);
        check("R5 trigger", int'(stat[7]), int'(k >= thr));
      end
      push(8'hAA, 1'b0, 1'b0, 1'b0);
      check("R7 drop count", int'(stat[4:0]), 16);
      for (int j = 1; j <= 16; j++) begin
        check("R1 data order", int'(rd_data), int'(pat(t, j)));
        check("R4 brk", int'(stat[15]), int'((j % 5) == 0));
        check("R4 fer", int'(stat[13]), int'((j % 3) == 0));
        check("R4 per", int'(stat[12]), int'((j % 4) == 1));
        check("R7 ovr on newest", int'(stat[11]), int'(j == 16));
        check("R3 nonempty", int'(stat[14]), 0);
        pop();
      end
      check("R3 empty", int'(stat[14]), 1);
      check("R4 flags when empty", int'(stat & 16'hF81F), 16'h4000);
      check("R12 irq", int'(irq), 1);
    end

    // R6: writing 1 keeps the bit, writing 0 clears it
    wstat(16'hFFFF);
    check("R6 write one keeps", int'(stat[7]), 1);
    wstat(16'h0000);
    check("R6 write zero clears", int'(stat[7]), 0);
    check("R12 irq low", int'(irq), 0);

    // R8: idle timeout below threshold 4
    cfg_trig = 2'd1;
    qreset();
    push(8'h11, 1'b0, 1'b0, 1'b0);
    ticks(3);
    check("R8 three ticks", int'(stat[9]), 0);
    ticks(1);
    check("R8 fourth tick", int'(stat[9]), 1);
    check("R12 irq from timeout", int'(irq), 1);
    wstat(16'hFFFF);
    check("R6 tout write one", int'(stat[9]), 1);
    wstat(16'h0000);
    check("R6 tout write zero", int'(stat[9]), 0);
    push(8'h12, 1'b0, 1'b0, 1'b0);
    ticks(3);
    push(8'h13, 1'b0, 1'b0, 1'b0);
    ticks(3);
    check("R8 restart on arrival", int'(stat[9]), 0);
    ticks(1);
    check("R8 after restart", int'(stat[9]), 1);

    // R9: queue reset needs its enable
    fifo_rst_rx = 1'b1;
    tick();
    fifo_rst_rx = 1'b0;
    check("R9 no enable", int'(stat[4:0]), 3);
    qreset();
    check("R9 with enable", int'(stat[4:0]), 0);

    // R11: 7-bit mode
    cfg_seven = 1'b1;
    push(8'hFF, 1'b0, 1'b0, 1'b0);
    check("R11 seven bit", int'(rd_data), 8'h7F);
    cfg_seven = 1'b0;
    push(8'hFF, 1'b0, 1'b0, 1'b0);
    pop();
    check("R11 eight bit", int'(rd_data), 8'hFF);

    // R10: software reset
    sw_rst = 1'b1;
    tick();
    sw_rst = 1'b0;
    for (int c = 1; c <= 4; c++) begin
      check("R10 busy", int'(rst_busy), 1);
      check("R10 cleared", int'(stat[4:0]), 0);
      if (c == 2) begin
        rx_valid = 1'b1; rx_data = 8'h55;
      end else begin
        rx_valid = 1'b0;
      end
      tick();
    end
    rx_valid = 1'b0;
    check("R10 busy done", int'(rst_busy), 0);
    check("R10 status after", int'(stat), 16'h4000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule